// File: doc/BRIEF.md
# Video Input Timing Analyser

This block sits on the pixel clock of a parallel video input carrying HSYNC, VSYNC and DE. It measures the geometry of the stream and presents it as a set of status words: active width and height, the widths of both sync pulses, and the front and back porches in both directions. It also reports the polarity of each sync signal and a stream-present flag.

Sync polarity is worked out from the duty cycle of each sync line. The asserted level is taken to be the shorter one. A sync line with no edge for a full timeout window is reported as absent. The measurement words are rebuilt from live counters while a frame runs. They are copied to the outputs together at the leading edge of VSYNC, so a reader never sees values taken from two different frames.

The stream-present flag combines three conditions: the link-lock input, a clock-running input supplied by an external clock monitor, and DE activity within a programmable number of pixel clocks. VSYNC edges are expected to coincide with HSYNC leading edges. Every porch and sync pulse is expected to be at least one clock long.

Top module: `vid_timing_meter`

## Requirements
- R1: After reset, all eight measurement outputs are 0, both polarity codes are 2 and `stream_ok` is 0.
- R2: Each polarity code is 2-bit. Code 1 means active high: the high level is the shorter one in each period. Code 0 means active low: the low level is strictly shorter, or the two are equal. Code 2 means not present: fewer than two edges have been seen since reset, or the sync line has held still for `SYNC_TO` clocks or more. Code 3 never appears.
- R3: `hs_width` is the number of pixel clocks during which HSYNC is asserted.
- R4: `h_back` is the number of pixel clocks from HSYNC deassertion to the first DE=1 pixel of the line.
- R5: `h_front` is the number of DE=0 pixel clocks from the last DE=1 pixel of a line to HSYNC assertion. It is taken from the last active line of the frame.
- R6: `act_width` is the number of DE=1 pixels in the last active line. `act_height` is the number of lines that contain DE=1 in the frame.
- R7: `vs_width` is the number of lines during which VSYNC is asserted. `v_back` is the number of lines from VSYNC deassertion to the first line with DE=1. `v_front` is the number of whole lines between the last active line and VSYNC assertion.
- R8: `stream_ok` is 1 only when all of the following hold: `link_locked` is 1, `clk_ok` is 1, and a DE edge has occurred within the last `de_limit` pixel clocks. If any one of them fails, the flag is 0.
- R9: The eight measurement outputs change only in the cycle after a VSYNC leading edge. While the sync lines are absent, the outputs keep their last values.
- R10: Inverting the polarity of HSYNC and VSYNC changes only the polarity codes; all measurements stay the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_locked | input | 1 | Deserialiser link lock |
| clk_ok | input | 1 | Pixel clock running, from an external clock monitor |
| hs_in | input | 1 | Raw HSYNC |
| vs_in | input | 1 | Raw VSYNC |
| de_in | input | 1 | Data enable, active high |
| de_limit | input | CNT_W | DE inactivity timeout in pixel clocks |
| act_width | output | CNT_W | Active pixels per line |
| act_height | output | CNT_W | Active lines per frame |
| hs_width | output | CNT_W | HSYNC pulse width, in clocks |
| vs_width | output | CNT_W | VSYNC pulse width, in lines |
| h_back | output | CNT_W | Horizontal back porch, in clocks |
| h_front | output | CNT_W | Horizontal front porch, in clocks |
| v_back | output | CNT_W | Vertical back porch, in lines |
| v_front | output | CNT_W | Vertical front porch, in lines |
| hs_code | output | 2 | HSYNC polarity code |
| vs_code | output | 2 | VSYNC polarity code |
| stream_ok | output | 1 | Stream present |

## Verification
The hardest state to reach is a polarity code returning to "not present" while DE keeps moving. Reaching it needs a stream whose sync lines are valid, then fall silent for longer than the sync timeout while the data enable keeps toggling. The bench first drives full frames, then holds both sync lines low and toggles DE alone for more than `SYNC_TO` clocks. It then checks three things: both codes read 2, `stream_ok` stays high, and the measurement outputs still hold the previous frame's values. Polarity inversion is reached by replaying one geometry with both sync lines inverted, and the bench expects the same measurements with different codes.

// File: rtl/vid_timing_meter.sv
`timescale 1ns/1ps
module vid_timing_meter #(
  parameter int CNT_W   = 16,
  parameter int SYNC_TO = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_locked,
  input  logic             clk_ok,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             de_in,
  input  logic [CNT_W-1:0] de_limit,
  output logic [CNT_W-1:0] act_width,
  output logic [CNT_W-1:0] act_height,
  output logic [CNT_W-1:0] hs_width,
  output logic [CNT_W-1:0] vs_width,
  output logic [CNT_W-1:0] h_back,
  output logic [CNT_W-1:0] h_front,
  output logic [CNT_W-1:0] v_back,
  output logic [CNT_W-1:0] v_front,
  output logic [1:0]       hs_code,
  output logic [1:0]       vs_code,
  output logic             stream_ok
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TO  = CNT_W'(SYNC_TO);

  logic [1:0] raw, raw_q, act, act_q;
  logic [3:0] pol_v;
  logic       de_q;

  assign raw = {vs_in, hs_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [CNT_W-1:0] run, hi_len, lo_len;
    logic [1:0]       seen;
    logic [1:0]       code;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run    <= '0;
        hi_len <= '0;
        lo_len <= '0;
        seen   <= '0;
      end else if (raw[g] != raw_q[g]) begin
        run <= '0;
        if (raw_q[g]) hi_len <= run + ONE;
        else          lo_len <= run + ONE;
        if (seen != 2'd2) seen <= seen + 2'd1;
      end else if (run != '1) begin
        run <= run + ONE;
      end

    assign code = (seen != 2'd2 || run >= TO) ? 2'd2 :
                  (hi_len < lo_len) ? 2'd1 : 2'd0;
    assign pol_v[2*g +: 2] = code;
    assign act[g] = (code == 2'd1) ? raw[g] :
                    (code == 2'd0) ? ~raw[g] : 1'b0;
  end

  assign hs_code = pol_v[1:0];
  assign vs_code = pol_v[3:2];

  logic hs_rise, hs_fall, vs_rise, vs_fall, de_rise, de_fall, frame_end;
  assign hs_rise   = act[0] & ~act_q[0];
  assign hs_fall   = ~act[0] & act_q[0];
  assign vs_rise   = act[1] & ~act_q[1];
  assign vs_fall   = ~act[1] & act_q[1];
  assign de_rise   = de_in & ~de_q;
  assign de_fall   = ~de_in & de_q;
  assign frame_end = vs_rise;

  logic [CNT_W-1:0] pcnt, lcnt, vfp_cnt, hgt_cnt, de_cnt;
  logic [CNT_W-1:0] s_hsw, s_hbp, s_wid, s_hfp, s_vsw, s_vbp;
  logic             line_act, frame_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      raw_q <= '0; act_q <= '0; de_q <= 1'b0;
      pcnt <= '0; lcnt <= '0; vfp_cnt <= '0; hgt_cnt <= '0; de_cnt <= '1;
      s_hsw <= '0; s_hbp <= '0; s_wid <= '0; s_hfp <= '0; s_vsw <= '0; s_vbp <= '0;
      line_act <= 1'b0; frame_act <= 1'b0;
      act_width <= '0; act_height <= '0; hs_width <= '0; vs_width <= '0;
      h_back <= '0; h_front <= '0; v_back <= '0; v_front <= '0;
    end else begin
      raw_q <= raw;
      act_q <= act;
      de_q  <= de_in;

      de_cnt <= (de_rise | de_fall) ? '0 : de_cnt + CNT_W'(de_cnt != '1);
      pcnt   <= (hs_rise | hs_fall | de_rise | de_fall) ? '0 : pcnt + CNT_W'(pcnt != '1);

      if (hs_fall) s_hsw <= pcnt + ONE;
      if (de_fall) s_wid <= pcnt + ONE;
      if (de_rise) begin
        s_hbp    <= pcnt + ONE;
        line_act <= 1'b1;
        hgt_cnt  <= hgt_cnt + ONE;
        if (!frame_act) begin
          s_vbp     <= lcnt;
          frame_act <= 1'b1;
        end
      end
      if (hs_rise) begin
        if (line_act) s_hfp <= pcnt + ONE;
        line_act <= 1'b0;
      end

      if (vs_rise | vs_fall) lcnt <= '0;
      else if (hs_rise)      lcnt <= lcnt + ONE;
      if (vs_fall) s_vsw <= lcnt + ONE;

      if (de_fall)      vfp_cnt <= '0;
      else if (hs_rise) vfp_cnt <= vfp_cnt + ONE;

      if (frame_end) begin
        act_width  <= s_wid;
        act_height <= hgt_cnt;
        hs_width   <= s_hsw;
        vs_width   <= s_vsw;
        h_back     <= s_hbp;
        h_front    <= s_hfp;
        v_back     <= s_vbp;
        v_front    <= vfp_cnt;
        hgt_cnt    <= '0;
        frame_act  <= 1'b0;
      end
    end

  assign stream_ok = link_locked & clk_ok & (de_cnt < de_limit);
endmodule

// File: rtl/vid_timing_meter_chk.sv
`timescale 1ns/1ps
module vid_timing_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_locked,
  input logic             clk_ok,
  input logic             frame_end,
  input logic [CNT_W-1:0] act_width,
  input logic [CNT_W-1:0] act_height,
  input logic [CNT_W-1:0] h_back,
  input logic [CNT_W-1:0] v_front,
  input logic [1:0]       hs_code,
  input logic [1:0]       vs_code,
  input logic             stream_ok
);
  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_code != 2'd3 && vs_code != 2'd3);

  // R8
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_locked |-> !stream_ok);

  // R8
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ok |-> !stream_ok);

  // R9
  atomic_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_width) && $stable(act_height) &&
                   $stable(h_back) && $stable(v_front));

  // R9
  commit_needs_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> vs_code != 2'd2);
endmodule

bind vid_timing_meter vid_timing_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_locked(link_locked), .clk_ok(clk_ok),
  .frame_end(frame_end), .act_width(act_width), .act_height(act_height),
  .h_back(h_back), .v_front(v_front), .hs_code(hs_code), .vs_code(vs_code),
  .stream_ok(stream_ok)
);

// File: tb/test_vid_timing_meter.sv
`timescale 1ns/1ps
module test_vid_timing_meter;
  localparam int CNT_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic link_locked = 1'b0, clk_ok = 1'b0, hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [CNT_W-1:0] de_limit = 16'd600;
  logic [CNT_W-1:0] act_width, act_height, hs_width, vs_width, h_back, h_front, v_back, v_front;
  logic [1:0] hs_code, vs_code;
  logic stream_ok;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vid_timing_meter #(.CNT_W(CNT_W), .SYNC_TO(1000)) i_vid_timing_meter (
    .clk(clk), .rst_n(rst_n), .link_locked(link_locked), .clk_ok(clk_ok),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in), .de_limit(de_limit),
    .act_width(act_width), .act_height(act_height), .hs_width(hs_width),
    .vs_width(vs_width), .h_back(h_back), .h_front(h_front), .v_back(v_back),
    .v_front(v_front), .hs_code(hs_code), .vs_code(vs_code), .stream_ok(stream_ok));

  task automatic chk(input string tag, input int actual, input int expct);
    nvec++;
    if (actual != expct) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, actual, expct);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  task automatic run_frames(input int hsw, hbp, wid, hfp, vsw, vbp, hgt, vfp,
                            input bit hpol, vpol, input int nfr);
    for (int f = 0; f < nfr; f++)
      for (int l = 0; l < vsw + vbp + hgt + vfp; l++)
        for (int p = 0; p < hsw + hbp + wid + hfp; p++) begin
          @(posedge clk); #1;
          hs_in = (p < hsw) ~^ hpol;
          vs_in = (l < vsw) ~^ vpol;
          de_in = (l >= vsw + vbp) && (l < vsw + vbp + hgt) &&
                  (p >= hsw + hbp) && (p < hsw + hbp + wid);
        end
  endtask

  task automatic check_geom(input string tag, input int hsw, hbp, wid, hfp, vsw, vbp, hgt, vfp);
    @(negedge clk);
    chk({tag, " R3 hs_width"}, hs_width, hsw);
    chk({tag, " R4 h_back"}, h_back, hbp);
    chk({tag, " R5 h_front"}, h_front, hfp);
    chk({tag, " R6 act_width"}, act_width, wid);
    chk({tag, " R6 act_height"}, act_height, hgt);
    chk({tag, " R7 vs_width"}, vs_width, vsw);
    chk({tag, " R7 v_back"}, v_back, vbp);
    chk({tag, " R7 v_front"}, v_front, vfp);
    chk({tag, " R8 stream_ok"}, stream_ok, 1);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 act_width", act_width, 0);
    chk("R1 act_height", act_height, 0);
    chk("R1 hs_width", hs_width, 0);
    chk("R1 v_front", v_front, 0);
    chk("R1 hs_code", hs_code, 2);
    chk("R1 vs_code", vs_code, 2);
    chk("R1 stream_ok", stream_ok, 0);
  endtask

  task automatic test_pattern_a();
    run_frames(4, 6, 20, 5, 2, 3, 8, 2, 1'b1, 1'b1, 4);
    check_geom("pattern A", 4, 6, 20, 5, 2, 3, 8, 2);
    chk("R2 hs_code active high", hs_code, 1);
    chk("R2 vs_code active high", vs_code, 1);
  endtask

  task automatic test_inverted();
    run_frames(4, 6, 20, 5, 2, 3, 8, 2, 1'b0, 1'b0, 4);
    check_geom("R10 inverted", 4, 6, 20, 5, 2, 3, 8, 2);
    chk("R2 R10 hs_code active low", hs_code, 0);
    chk("R2 R10 vs_code active low", vs_code, 0);
  endtask

  task automatic test_pattern_b();
    run_frames(3, 5, 16, 4, 3, 2, 10, 3, 1'b1, 1'b1, 4);
    check_geom("pattern B", 3, 5, 16, 4, 3, 2, 10, 3);
    chk("R2 hs_code B", hs_code, 1);
  endtask

  task automatic test_sync_lost();
    for (int i = 0; i < 1200; i++) begin
      @(posedge clk); #1;
      hs_in = 1'b0; vs_in = 1'b0; de_in = (i % 10) < 5;
    end
    @(negedge clk);
    chk("R2 hs_code timeout", hs_code, 2);
    chk("R2 vs_code timeout", vs_code, 2);
    chk("R8 stream_ok with DE only", stream_ok, 1);
    chk("R9 act_width held", act_width, 16);
    chk("R9 v_back held", v_back, 2);
  endtask

  task automatic toggle_de(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; de_in = (i % 10) < 5;
    end
  endtask

  task automatic test_stream_flag();
    @(posedge clk); #1; de_in = 1'b0;
    for (int i = 0; i < 700; i++) @(posedge clk);
    @(negedge clk);
    chk("R8 DE stalled", stream_ok, 0);
    toggle_de(50);
    @(negedge clk);
    chk("R8 DE resumed", stream_ok, 1);
    link_locked = 1'b0;
    toggle_de(20);
    @(negedge clk);
    chk("R8 link unlocked", stream_ok, 0);
    link_locked = 1'b1; clk_ok = 1'b0;
    toggle_de(20);
    @(negedge clk);
    chk("R8 clock stopped", stream_ok, 0);
    clk_ok = 1'b1;
    toggle_de(20);
    @(negedge clk);
    chk("R8 all conditions met", stream_ok, 1);
  endtask

  initial begin
    #(4 * 200000);
    nvec++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    #1 rst_n = 1'b1;
    link_locked = 1'b1; clk_ok = 1'b1;
    test_pattern_a();
    test_inverted();
    test_pattern_b();
    test_sync_lost();
    test_stream_flag();
    finish_run();
  end
endmodule